// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates among thirty level-sensitive interrupt requests for a small 8-bit processor core. Each request line has its own enable bit and a two-bit priority. A single global enable gates all of them. In every clock cycle the controller picks one winning request. When the core reports that it is at an instruction boundary, the controller hands the core a one-cycle take strobe, together with the winner's source number and its handler address.

The controller keeps a four-bit in-service mask, with one bit per priority level. This mask lets a running handler be interrupted only by a request of strictly higher priority. When the core executes its return-from-interrupt, the controller retires the most recent (highest) level, and the interrupted level becomes the one in force again. Clearing a request flag is the job of the peripheral that raised it.

Top module: `nest_irq_ctl`

## Requirements
- R1: On a take, `vec_o` equals 0x0003 + 8 × `src_o`. For example, source 0 gives 0x0003, source 1 gives 0x000B, source 10 gives 0x0053, source 15 gives 0x007B and source 29 gives 0x00EB. 0x0000 is never presented on a take.
- R2: Among pending requests, the one with the highest priority value wins. The priority of source n is `prio_i[2n+1:2n]`, with 3 the highest and 0 the lowest.
- R3: When several pending requests share the top priority, the lowest source number wins.
- R4: A request whose `en_i` bit is 0 is never taken.
- R5: While `gie_i` is 0, no interrupt is taken.
- R6: A take happens only when `ack_rdy_i` was 1 at the sampling clock edge. `take_o` then goes high for one cycle, in the cycle after that edge.
- R7: A take sets bit p of `insvc_o`, where p is the winner's priority level.
- R8: While any level is in service, a request is taken only if its priority is strictly above the highest in-service level. Requests at an equal or lower priority stay pending.
- R9: A `reti_i` pulse clears the highest set bit of `insvc_o`. Pending requests are then judged against the level below it. With the mask empty, `reti_i` has no effect.
- R10: A synchronous `rst` clears `insvc_o`, `take_o`, `vec_o` and `src_o`.
- R11: A request that stays asserted after it was taken is not taken again while its level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 30 | Level request, one bit per source |
| en_i | input | 30 | Per-source enable |
| prio_i | input | 60 | Two-bit priority per source, source n at bits [2n+1:2n] |
| gie_i | input | 1 | Global interrupt enable |
| ack_rdy_i | input | 1 | Core is at an instruction boundary and may accept a vector |
| reti_i | input | 1 | Core executed a return-from-interrupt |
| take_o | output | 1 | One-cycle take strobe |
| vec_o | output | 16 | Handler address, valid with `take_o` |
| src_o | output | 5 | Winning source number, valid with `take_o` |
| insvc_o | output | 4 | In-service mask, bit k for priority level k |

## Verification
The hardest state to reach from the ports is a two-deep nest, where lower and equal priority requests stay pending while the nest unwinds. The stimulus builds this in steps:
- It first takes a level-1 request.
- It then adds an equal-priority request and a level-0 request, and checks that neither is taken.
- It then injects a level-2 request that does preempt.
- It retires the two levels one at a time with `reti_i`.

After the first return, the bench checks that the level-1 requests still cannot enter. After the second return, it checks that the lower-numbered of the two tied level-1 sources is taken.

// File: rtl/nest_irq_ctl.sv
module nest_irq_ctl #(
  parameter  int NSRC       = 30,
  parameter  int NLVL       = 4,
  parameter  int VW         = 16,
  parameter  int VEC_BASE   = 3,
  parameter  int VEC_STRIDE = 8,
  localparam int PW         = $clog2(NLVL),
  localparam int SW         = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    req_i,
  input  logic [NSRC-1:0]    en_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic               gie_i,
  input  logic               ack_rdy_i,
  input  logic               reti_i,
  output logic               take_o,
  output logic [VW-1:0]      vec_o,
  output logic [SW-1:0]      src_o,
  output logic [NLVL-1:0]    insvc_o
);

  logic [NSRC-1:0] pend;
  logic            pick_v;
  logic [SW-1:0]   pick_idx;
  logic [PW-1:0]   pick_p;
  logic            act_v;
  logic [PW-1:0]   act_lvl;
  logic [NLVL-1:0] top_bit;
  logic            fire;

  assign pend = req_i & en_i & {NSRC{gie_i}};

  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    pick_p   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && (!pick_v || prio_i[i*PW +: PW] >= pick_p)) begin
        pick_v   = 1'b1;
        pick_idx = SW'(i);
        pick_p   = prio_i[i*PW +: PW];
      end
    end
  end

  always_comb begin
    act_v   = 1'b0;
    act_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (insvc_o[l]) begin
        act_v   = 1'b1;
        act_lvl = PW'(l);
      end
    end
  end

  assign top_bit = act_v ? (NLVL'(1) << act_lvl) : '0;
  assign fire    = ack_rdy_i && pick_v && (!act_v || pick_p > act_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o  <= 1'b0;
      vec_o   <= '0;
      src_o   <= '0;
      insvc_o <= '0;
    end else begin
      take_o  <= fire;
      insvc_o <= (insvc_o & ~(reti_i ? top_bit : '0)) |
                 (fire ? (NLVL'(1) << pick_p) : '0);
      if (fire) begin
        src_o <= pick_idx;
        vec_o <= VW'(VEC_BASE) + VW'(VEC_STRIDE) * VW'(pick_idx);
      end
    end
  end

endmodule

// File: rtl/nest_irq_ctl_chk.sv
module nest_irq_ctl_chk #(
  parameter int NLVL = 4,
  parameter int VW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            gie_i,
  input logic            ack_rdy_i,
  input logic            reti_i,
  input logic            take_o,
  input logic [VW-1:0]   vec_o,
  input logic [NLVL-1:0] insvc_o
);

  p_vec_shape_r1: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (vec_o != '0 && vec_o[2:0] == 3'd3));

  p_gie_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> !take_o);

  p_ack_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !ack_rdy_i |=> !take_o);

  p_mark_level_r7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> insvc_o != '0);

  p_pop_one_r9: assert property (@(posedge clk) disable iff (rst)
    (reti_i && insvc_o != '0) |=>
      (take_o || $countones(insvc_o) == $countones($past(insvc_o)) - 1));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!take_o && insvc_o == '0));

endmodule

bind nest_irq_ctl nest_irq_ctl_chk #(.NLVL(NLVL), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .gie_i(gie_i), .ack_rdy_i(ack_rdy_i),
  .reti_i(reti_i), .take_o(take_o), .vec_o(vec_o), .insvc_o(insvc_o)
);

// File: tb/test_nest_irq_ctl.sv
`timescale 1ns/1ps
module test_nest_irq_ctl;
  logic        clk = 0;
  logic        rst = 1;
  logic [29:0] req = '0, en = '0;
  logic [59:0] prio = '0;
  logic        gie = 0, ack = 0, reti = 0;
  logic        take;
  logic [15:0] vec;
  logic [4:0]  src;
  logic [3:0]  insvc;
  int nchk = 0, nerr = 0;

  nest_irq_ctl i_nest_irq_ctl (
    .clk(clk), .rst(rst), .req_i(req), .en_i(en), .prio_i(prio),
    .gie_i(gie), .ack_rdy_i(ack), .reti_i(reti),
    .take_o(take), .vec_o(vec), .src_o(src), .insvc_o(insvc)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic arm(input int n, input int p);
    en[n] = 1'b1;
    prio[2*n +: 2] = 2'(p);
    req[n] = 1'b1;
  endtask

  task automatic clean();
    req = '0; en = '0; prio = '0;
    reti = 1;
    repeat (4) tick();
    reti = 0;
    tick();
  endtask

  task automatic t_reset();
    chk(take == 0 && insvc == 0 && vec == 0 && src == 0, "R10 reset state",
        {take, insvc, vec}, 0);
  endtask

  task automatic t_vectors();
    int list[4] = '{0, 1, 15, 29};
    foreach (list[k]) begin
      int n = list[k];
      clean();
      gie = 1; ack = 1;
      arm(n, 0);
      tick();
      chk(take == 1, "R6 take strobe", take, 1);
      chk(vec == 16'(3 + 8 * n), "R1 vector", vec, 3 + 8 * n);
      chk(src == 5'(n), "R1 source number", src, n);
      chk(insvc == 4'b0001, "R7 level 0 marked", insvc, 1);
      tick();
      chk(take == 0, "R11 no retake while in service", take, 0);
    end
    clean();
  endtask

  task automatic t_priority();
    gie = 1; ack = 1;
    arm(5, 1); arm(7, 3); arm(2, 3); arm(20, 2);
    tick();
    chk(take == 1 && src == 5'd2, "R2 R3 highest priority, lowest index", src, 2);
    chk(insvc == 4'b1000, "R7 level 3 marked", insvc, 8);
    clean();
  endtask

  task automatic t_gating();
    gie = 1; ack = 1;
    req[4] = 1; prio[9:8] = 2'd3; en[4] = 0;
    repeat (3) tick();
    chk(take == 0 && insvc == 0, "R4 disabled source ignored", insvc, 0);
    en[4] = 1; gie = 0;
    repeat (2) tick();
    chk(take == 0 && insvc == 0, "R5 global disable", insvc, 0);
    gie = 1; ack = 0;
    repeat (2) tick();
    chk(take == 0 && insvc == 0, "R6 held off without ack ready", insvc, 0);
    ack = 1;
    tick();
    chk(take == 1 && src == 5'd4, "R6 taken once ack ready", src, 4);
    clean();
  endtask

  task automatic t_nesting();
    gie = 1; ack = 1;
    arm(3, 1);
    tick();
    chk(take == 1 && src == 5'd3 && insvc == 4'b0010, "R7 first level", insvc, 2);
    arm(6, 1);
    tick();
    chk(take == 0 && insvc == 4'b0010, "R8 equal priority waits", insvc, 2);
    arm(9, 0);
    tick();
    chk(take == 0, "R8 lower priority waits", take, 0);
    arm(10, 2);
    tick();
    chk(take == 1 && src == 5'd10 && vec == 16'h0053, "R8 preempt by higher", vec, 16'h53);
    chk(insvc == 4'b0110, "R7 nested mask", insvc, 6);
    req[10] = 0; reti = 1;
    tick();
    chk(insvc == 4'b0010 && take == 0, "R9 pop top level", insvc, 2);
    reti = 0;
    tick();
    chk(take == 0, "R8 equal level still held after pop", take, 0);
    reti = 1;
    tick();
    chk(insvc == 4'b0000 && take == 0, "R9 pop last level", insvc, 0);
    reti = 0;
    tick();
    chk(take == 1 && src == 5'd3 && insvc == 4'b0010, "R9 R3 pending resumes", src, 3);
    clean();
  endtask

  task automatic t_reti_empty();
    reti = 1;
    tick();
    reti = 0;
    chk(insvc == 0 && take == 0, "R9 return with empty mask", insvc, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_vectors();
    t_priority();
    t_gating();
    t_nesting();
    t_reti_empty();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule